// File: doc/BRIEF.md
# Packet-Threshold Buffer with Fixed-Length Framing

This block is a synchronous first-in first-out store for 32-bit packet words. It sits between a host bus bridge and a processing core, in either direction. A producer pushes one word per cycle. A downstream consumer pulls words through a streaming source port. By default the store holds 2048 words, which is two packets of 1024 words each, so one packet can fill while the previous one drains.

A fill threshold is supplied at a port, normally 1022. When the number of stored words is at or above this threshold, the packet-available flag is raised. The consumer uses that flag to learn that a whole packet is present. In the receive direction, the same flag tells the host that a processed packet is ready.

The source port marks the first word of each fixed-length packet with start-of-packet and the last word with end-of-packet. It does this with a word counter that wraps at the packet length.

Top module: `pkt_thresh_fifo`

## Requirements
- R1: After reset, the fill level is 0, and full, overflow, packet-available, start-of-packet and end-of-packet are all low.
- R2: Words leave the source port in the order they were pushed, with no loss and no duplication. The port shows the oldest stored word whenever the store is not empty.
- R3: The fill level equals the accepted pushes minus the accepted pops since reset. This holds when a push and a pop happen in the same cycle.
- R4: Full is high exactly when the fill level equals the depth (2048). A push while full is dropped, even if a pop happens in the same cycle, and the dropped word never appears at the output.
- R5: A dropped push sets the overflow flag. The flag stays high until reset.
- R6: Packet-available is high exactly when the fill level is greater than or equal to the threshold input. A change of the threshold takes effect in the same cycle.
- R7: A word is popped only in a cycle where the enable input is high and the store is not empty. Enable while empty changes nothing.
- R8: Start-of-packet is high with every word whose index since reset, modulo 1024, is 0. End-of-packet is high with every word whose index is 1023. Both are low while the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thresh | input | 12 | Packet-available fill threshold |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| full | output | 1 | Store holds DEPTH words |
| overflow | output | 1 | Sticky flag: a push was dropped |
| fill_level | output | 12 | Number of words stored |
| src_dav | output | 1 | Packet available (fill at or above threshold) |
| src_ena | input | 1 | Consumer enable; pops one word when not empty |
| src_dat | output | 32 | Oldest stored word |
| src_sop | output | 1 | Current word starts a packet |
| src_eop | output | 1 | Current word ends a packet |

## Verification
The bench applies three kinds of traffic:
- A burst that fills the store without reading. This walks packet-available across the threshold and drives the store into full and overflow.
- Steady streaming with push and pop in the same cycle. This separates a correct fill count from one that misses simultaneous operations, and it carries the word counter through several packet boundaries.
- Random enables and writes, including enables while empty. These expose any pop that happens without data, and any wrong ordering.

The threshold is also moved while the store is part full. This shows whether the flag compares against the live input or against a fixed value.

// File: rtl/pkt_fifo_pkg.sv
// Shared sizing defaults for the packet-threshold buffer.
package pkt_fifo_pkg;
    localparam int unsigned DATA_W_DEF  = 32;
    localparam int unsigned DEPTH_DEF   = 2048;
    localparam int unsigned PKT_LEN_DEF = 1024;

    // Width of a counter that must hold values 0..max_val inclusive.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/fifo_ptr_ctrl.sv
// Pointer and occupancy control for a circular store.
// Accepts a push only when not full and a pop only when not empty;
// a push on a full store is refused even if a pop occurs in the same cycle.
// Assumes DEPTH >= 2.
module fifo_ptr_ctrl #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = pkt_fifo_pkg::cnt_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Status decode from the occupancy count.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        push_ok = push_req && !full;
        pop_ok  = pop_req && !empty;
    end

    // Write pointer advances per accepted push, wrapping at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
    end

    // Read pointer advances per accepted pop, wrapping at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (pop_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
    end

    // Occupancy: net change of push and pop, unchanged when both occur.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fifo_store.sv
// Word storage: one synchronous write port, one asynchronous read port.
// Contents are not reset; the control logic never exposes unwritten words.
module fifo_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 2048,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word at the read pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_framer.sv
// Fixed-length framing and packet-available detection.
// Counts popped words modulo PKT_LEN; flags the first and last word of each
// packet while a word is present. Packet-available compares the live fill
// level against the threshold input. Assumes PKT_LEN >= 2.
module pkt_framer #(
    parameter int unsigned PKT_LEN = 1024,
    parameter int unsigned CNT_W   = 12,
    localparam int unsigned IDX_W  = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_ok,
    input  logic             empty,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    output logic             sop,
    output logic             eop,
    output logic             pkt_avail
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    logic [IDX_W-1:0] word_idx;

    // Position of the head word within its packet, wrapping at PKT_LEN-1.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_idx <= '0;
        else if (pop_ok) word_idx <= (word_idx == LAST_IDX) ? '0 : word_idx + 1'b1;
    end

    // Framing markers and threshold flag.
    always_comb begin
        sop       = !empty && (word_idx == '0);
        eop       = !empty && (word_idx == LAST_IDX);
        pkt_avail = (count >= thresh);
    end
endmodule

// File: rtl/pkt_thresh_fifo.sv
// Packet-threshold buffer: circular store plus fixed-length framing on a
// streaming source port. Overflow is a sticky flag cleared only by reset.
// Single clock domain; synchronous active-low reset.
module pkt_thresh_fifo #(
    parameter int unsigned DATA_W  = pkt_fifo_pkg::DATA_W_DEF,
    parameter int unsigned DEPTH   = pkt_fifo_pkg::DEPTH_DEF,
    parameter int unsigned PKT_LEN = pkt_fifo_pkg::PKT_LEN_DEF,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = pkt_fifo_pkg::cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              overflow,
    output logic [CNT_W-1:0]  fill_level,
    output logic              src_dav,
    input  logic              src_ena,
    output logic [DATA_W-1:0] src_dat,
    output logic              src_sop,
    output logic              src_eop
);
    logic             push_ok, pop_ok, empty;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_en), .pop_req(src_ena),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(fill_level), .full(full), .empty(empty)
    );

    fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(src_dat)
    );

    pkt_framer #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .pop_ok(pop_ok), .empty(empty),
        .count(fill_level), .thresh(thresh),
        .sop(src_sop), .eop(src_eop), .pkt_avail(src_dav)
    );

    // Sticky record of any refused push.
    always_ff @(posedge clk) begin
        if (!rst_n)              overflow <= 1'b0;
        else if (wr_en && full)  overflow <= 1'b1;
    end
endmodule

// File: rtl/pkt_thresh_fifo_chk.sv
// Port-level checker for the packet-threshold buffer, bound to the top.
module pkt_thresh_fifo_chk #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             src_ena,
    input logic             full,
    input logic             overflow,
    input logic [CNT_W-1:0] fill_level,
    input logic             src_sop,
    input logic             src_eop
);
    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CNT_W'(DEPTH));
    // R4
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (fill_level == CNT_W'(DEPTH)));
    // R4
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !src_ena) |=> (fill_level == CNT_W'(DEPTH)));
    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R5
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> overflow);
    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && !wr_en) |=> (fill_level == '0));
    // R8
    frame_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sop || src_eop) |-> (fill_level != '0));
    // R8
    frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_sop && src_eop));
endmodule

bind pkt_thresh_fifo pkt_thresh_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .src_ena(src_ena),
    .full(full), .overflow(overflow), .fill_level(fill_level),
    .src_sop(src_sop), .src_eop(src_eop)
);

// File: tb/tb_pkt_thresh_fifo.sv
`timescale 1ns/1ps
module tb_pkt_thresh_fifo;
    localparam int DEPTH = 2048;
    localparam int PKT   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] thresh = 12'd1022;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        src_ena = 1'b0;
    logic        full, overflow, src_dav, src_sop, src_eop;
    logic [11:0] fill_level;
    logic [31:0] src_dat;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state
    int unsigned q[$];
    int widx = 0;
    bit ovf  = 0;

    always #2 clk = ~clk;

    pkt_thresh_fifo dut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh), .wr_en(wr_en),
        .wr_data(wr_data), .full(full), .overflow(overflow),
        .fill_level(fill_level), .src_dav(src_dav), .src_ena(src_ena),
        .src_dat(src_dat), .src_sop(src_sop), .src_eop(src_eop)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every visible output against the model.
    task automatic compare();
        int sz = q.size();
        chk(fill_level == 12'(sz), "R3 fill level", fill_level, sz);
        chk(full == (sz == DEPTH), "R4 full", full, sz == DEPTH);
        chk(overflow == ovf, "R5 overflow", overflow, ovf);
        chk(src_dav == (sz >= int'(thresh)), "R6 packet available", src_dav, sz >= int'(thresh));
        if (sz > 0) begin
            chk(src_dat == q[0], "R2 head word", src_dat, q[0]);
            chk(src_sop == (widx == 0), "R8 sop", src_sop, widx == 0);
            chk(src_eop == (widx == PKT - 1), "R8 eop", src_eop, widx == PKT - 1);
        end else begin
            chk(!src_sop && !src_eop, "R8 markers idle when empty", {src_sop, src_eop}, 0);
        end
    endtask

    // One clock: drive inputs, check, advance the model at the edge.
    task automatic cycle(bit we, logic [31:0] d, bit ena);
        bit push, pop;
        wr_en = we; wr_data = d; src_ena = ena;
        #1 compare();
        pop  = ena && q.size() > 0;           // R7
        push = we && q.size() < DEPTH;        // R4: full refuses even with pop
        if (we && !push) ovf = 1;
        @(posedge clk);
        if (pop) begin
            void'(q.pop_front());
            widx = (widx == PKT - 1) ? 0 : widx + 1;
        end
        if (push) q.push_back(d);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; src_ena = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q.delete(); widx = 0; ovf = 0;
        #1;
        // R1 reset state
        chk(fill_level == 0 && !full && !overflow && !src_sop && !src_eop,
            "R1 reset state", {fill_level, full, overflow, src_sop, src_eop}, 0);
        chk(src_dav == (thresh == 0), "R1 dav after reset", src_dav, thresh == 0);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R7: enable while empty has no effect
        for (int i = 0; i < 5; i++) cycle(0, 0, 1);
        // R6: fill across threshold, no reads
        for (int i = 0; i < 1030; i++) cycle(1, 32'hA500_0000 + i, 0);
        // R6: threshold moved while part full
        thresh = 12'd1500; cycle(0, 0, 0);
        thresh = 12'd1030; cycle(0, 0, 0);
        thresh = 12'd1022;
        // R3: simultaneous push and pop, streaming over packet boundaries
        for (int i = 0; i < 3 * PKT; i++) cycle(1, $urandom, 1);
        // R4 R5: fill to full and push past it, incl. push+pop while full
        while (q.size() < DEPTH) cycle(1, $urandom, 0);
        for (int i = 0; i < 6; i++) cycle(1, 32'hDEAD_0000 + i, 0);
        cycle(1, 32'hBAD0_BAD0, 1);
        // Drain with random enables and writes; overflow stays sticky
        for (int i = 0; i < 6000; i++) cycle(($urandom % 4) == 0, $urandom, ($urandom % 3) != 0);
        while (q.size() > 0) cycle(0, 0, 1);
        for (int i = 0; i < 4; i++) cycle(0, 0, 1);
        // R1 R5: reset clears overflow
        do_reset();
        for (int i = 0; i < 2 * PKT + 50; i++) cycle(($urandom % 2) == 0, $urandom, ($urandom % 2) == 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule